// File: doc/BRIEF.md
# Special-Purpose Register Access Unit

This block holds the special-purpose register space of a small 32-bit processor core. The execute stage presents a 16-bit register number, built from a 5-bit group placed at bit 11 and an 11-bit index, together with write data, a write enable and the value the destination register held before the instruction. The block returns the read data combinationally. Writes land on the rising clock edge.

Inside the block are the trap state: the vector base, the saved PC, the faulting effective address and the saved status word. It also holds the plain status register, an interrupt mask, a sticky interrupt-pending word, a power-control word, a 64-bit multiply-accumulate register split into two 32-bit halves, and a parameterised number of 32-entry shadow register banks. The current and previous PC come in from the pipeline. A PC redirect and a halt request leave the block as registered one-cycle strobes. Reading a number that decodes to nothing hands back the caller's old destination value, so the instruction has no visible effect.

Top module: `spr_unit`

## Requirements
- R1: The register number is (group << 11) + index. In group 0, the vector base (index 11), status (17), saved PC (32), effective address (48) and saved status (64) read back the last value written to them, and a write to one leaves the others unchanged.
- R2: After a synchronous active-high reset, every writable register reads 0, and group 0 index 0 reads the VERSION parameter.
- R3: A write to the pending word (group 9, index 2) clears each pending bit that is 1 in the write data and keeps the rest.
- R4: A bit that is high on irq_set becomes pending on the next edge, even if a clearing write to that bit happens in the same cycle.
- R5: A write to the mask (group 9, index 0) replaces the whole mask.
- R6: Group 5 index 1 is accumulator bits 31:0 and index 2 is bits 63:32. Writing one half leaves the other half unchanged.
- R7: Shadow entries occupy group 0 from index 1024 through 1024+32*BANKS-1. Offset o addresses bank o/32, entry o%32, and each entry holds its own value.
- R8: A read of any other register number returns spr_rd_prev, and a write to such a number changes no register.
- R9: Group 0 index 16 reads cur_pc and index 18 reads prev_pc. A write to index 18 has no effect.
- R10: A write to index 16 with data different from cur_pc raises redirect_o and dslot_clr_o for exactly the next cycle, with redirect_pc_o equal to the data. A write equal to cur_pc raises nothing.
- R11: A write to the power word (group 8, index 0) is stored. When bit 4 (doze) or bit 5 (sleep) of the data is 1, halt_o is high for the next cycle and resume_pc_o equals cur_pc+4 taken at the write.
- R12: Read data reflects a write in the first cycle after the write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spr_addr | input | 16 | Register number |
| spr_we | input | 1 | Write enable |
| spr_wdata | input | XLEN | Write data |
| spr_rd_prev | input | XLEN | Previous destination value |
| spr_rdata | output | XLEN | Read data |
| cur_pc | input | XLEN | Current PC |
| prev_pc | input | XLEN | Previous PC |
| irq_set | input | XLEN | Incoming interrupt bits |
| redirect_o | output | 1 | PC redirect strobe |
| redirect_pc_o | output | XLEN | Redirect target |
| dslot_clr_o | output | 1 | Delay-slot flag clear strobe |
| halt_o | output | 1 | Halt request strobe |
| resume_pc_o | output | XLEN | PC at which to resume after the halt |

## Verification
The bench builds the unit with BANKS=2, which gives 64 shadow entries. At that size the bench can read all 65536 register numbers against an arithmetic model, each with its own previous-destination value, and write a strided sample of the undecoded numbers. Every shadow entry, the upper shadow boundary and every decode hole are therefore checked exactly. The strobes, the pending-word priority and the independence of the accumulator halves are checked with directed writes.

// File: rtl/spr_pkg.sv
package spr_pkg;
    localparam int GRP_SHIFT = 11;

    function automatic logic [15:0] spr_num(input int grp, input int idx);
        return 16'((grp << GRP_SHIFT) + idx);
    endfunction

    localparam logic [15:0] A_VER   = spr_num(0, 0);
    localparam logic [15:0] A_EVB   = spr_num(0, 11);
    localparam logic [15:0] A_NPC   = spr_num(0, 16);
    localparam logic [15:0] A_SR    = spr_num(0, 17);
    localparam logic [15:0] A_PPC   = spr_num(0, 18);
    localparam logic [15:0] A_EPC   = spr_num(0, 32);
    localparam logic [15:0] A_EEA   = spr_num(0, 48);
    localparam logic [15:0] A_ESR   = spr_num(0, 64);
    localparam logic [15:0] A_MACLO = spr_num(5, 1);
    localparam logic [15:0] A_MACHI = spr_num(5, 2);
    localparam logic [15:0] A_PWR   = spr_num(8, 0);
    localparam logic [15:0] A_IMASK = spr_num(9, 0);
    localparam logic [15:0] A_ISTAT = spr_num(9, 2);

    localparam int SHADOW_BASE = 1024;
    localparam int BANK_REGS   = 32;
    localparam int PWR_DOZE    = 4;
    localparam int PWR_SLEEP   = 5;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_VER, SEL_EVB, SEL_NPC, SEL_SR, SEL_PPC, SEL_EPC,
        SEL_EEA, SEL_ESR, SEL_SHADOW, SEL_MACLO, SEL_MACHI, SEL_PWR,
        SEL_IMASK, SEL_ISTAT
    } spr_sel_e;
endpackage

// File: rtl/spr_decode.sv
module spr_decode
    import spr_pkg::*;
#(
    parameter int BANKS = 2,
    parameter int SH_IW = 6
) (
    input  logic [15:0]      addr,
    output spr_sel_e         sel,
    output logic [SH_IW-1:0] sh_idx
);
    localparam int SH_ENTRIES = BANKS * BANK_REGS;

    logic [10:0] sh_off;
    assign sh_off = {1'b0, addr[9:0]};

    always_comb begin
        sel    = SEL_NONE;
        sh_idx = sh_off[SH_IW-1:0];
        case (addr)
            A_VER:   sel = SEL_VER;
            A_EVB:   sel = SEL_EVB;
            A_NPC:   sel = SEL_NPC;
            A_SR:    sel = SEL_SR;
            A_PPC:   sel = SEL_PPC;
            A_EPC:   sel = SEL_EPC;
            A_EEA:   sel = SEL_EEA;
            A_ESR:   sel = SEL_ESR;
            A_MACLO: sel = SEL_MACLO;
            A_MACHI: sel = SEL_MACHI;
            A_PWR:   sel = SEL_PWR;
            A_IMASK: sel = SEL_IMASK;
            A_ISTAT: sel = SEL_ISTAT;
            default: begin
                // group 0, index bit 10 set, offset within populated banks
                if (addr[15:11] == 5'd0 && addr[10] && sh_off < 11'(SH_ENTRIES))
                    sel = SEL_SHADOW;
            end
        endcase
    end
endmodule

// File: rtl/spr_shadow_bank.sv
module spr_shadow_bank
    import spr_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int BANKS = 2,
    parameter int SH_IW = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SH_IW-1:0] widx,
    input  logic [XLEN-1:0]  wdata,
    input  logic [SH_IW-1:0] ridx,
    output logic [XLEN-1:0]  rdata
);
    logic [XLEN-1:0] bank_rd [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [XLEN-1:0] regs_d [BANK_REGS];
        logic [XLEN-1:0] regs_q [BANK_REGS];

        always_comb begin
            regs_d = regs_q;
            if (we && int'(widx >> 5) == b)
                regs_d[widx[4:0]] = wdata;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < BANK_REGS; i++) regs_q[i] <= '0;
            end else begin
                regs_q <= regs_d;
            end
        end

        assign bank_rd[b] = regs_q[ridx[4:0]];
    end

    always_comb begin
        rdata = '0;
        for (int b = 0; b < BANKS; b++)
            if (int'(ridx >> 5) == b) rdata = bank_rd[b];
    end
endmodule

// File: rtl/spr_unit.sv
module spr_unit
    import spr_pkg::*;
#(
    parameter int          XLEN    = 32,
    parameter int          BANKS   = 2,
    parameter logic [31:0] VERSION = 32'h1200_0301
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [15:0]     spr_addr,
    input  logic            spr_we,
    input  logic [XLEN-1:0] spr_wdata,
    input  logic [XLEN-1:0] spr_rd_prev,
    output logic [XLEN-1:0] spr_rdata,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] prev_pc,
    input  logic [XLEN-1:0] irq_set,
    output logic            redirect_o,
    output logic [XLEN-1:0] redirect_pc_o,
    output logic            dslot_clr_o,
    output logic            halt_o,
    output logic [XLEN-1:0] resume_pc_o
);
    localparam int SH_ENTRIES = BANKS * BANK_REGS;
    localparam int SH_IW      = $clog2(SH_ENTRIES);

    typedef struct packed {
        logic [XLEN-1:0]   evb;
        logic [XLEN-1:0]   sr;
        logic [XLEN-1:0]   epc;
        logic [XLEN-1:0]   eea;
        logic [XLEN-1:0]   esr;
        logic [XLEN-1:0]   imask;
        logic [XLEN-1:0]   istat;
        logic [XLEN-1:0]   pwr;
        logic [2*XLEN-1:0] mac;
        logic              redirect;
        logic [XLEN-1:0]   redirect_pc;
        logic              halt;
        logic [XLEN-1:0]   resume_pc;
    } spr_state_t;

    spr_state_t       st_d, st_q;
    spr_sel_e         sel;
    logic [SH_IW-1:0] sh_idx;
    logic [XLEN-1:0]  sh_rdata;
    logic [XLEN-1:0]  istat_clr;
    logic             hit;
    logic [XLEN-1:0]  istat_q;
    logic [2*XLEN-1:0] mac_q;

    spr_decode #(.BANKS(BANKS), .SH_IW(SH_IW)) i_decode (
        .addr   (spr_addr),
        .sel    (sel),
        .sh_idx (sh_idx)
    );

    spr_shadow_bank #(.XLEN(XLEN), .BANKS(BANKS), .SH_IW(SH_IW)) i_shadow (
        .clk   (clk),
        .rst   (rst),
        .we    (spr_we && sel == SEL_SHADOW),
        .widx  (sh_idx),
        .wdata (spr_wdata),
        .ridx  (sh_idx),
        .rdata (sh_rdata)
    );

    // next-state process
    always_comb begin
        st_d          = st_q;
        st_d.redirect = 1'b0;
        st_d.halt     = 1'b0;
        istat_clr     = (spr_we && sel == SEL_ISTAT) ? spr_wdata : '0;
        // incoming set bits win over a clearing write in the same cycle
        st_d.istat    = (st_q.istat & ~istat_clr) | irq_set;
        if (spr_we) begin
            case (sel)
                SEL_EVB:   st_d.evb = spr_wdata;
                SEL_SR:    st_d.sr  = spr_wdata;
                SEL_EPC:   st_d.epc = spr_wdata;
                SEL_EEA:   st_d.eea = spr_wdata;
                SEL_ESR:   st_d.esr = spr_wdata;
                SEL_IMASK: st_d.imask = spr_wdata;
                SEL_MACLO: st_d.mac[XLEN-1:0] = spr_wdata;
                SEL_MACHI: st_d.mac[2*XLEN-1:XLEN] = spr_wdata;
                SEL_NPC: begin
                    if (spr_wdata != cur_pc) begin
                        st_d.redirect    = 1'b1;
                        st_d.redirect_pc = spr_wdata;
                    end
                end
                SEL_PWR: begin
                    st_d.pwr = spr_wdata;
                    if (spr_wdata[PWR_DOZE] || spr_wdata[PWR_SLEEP]) begin
                        st_d.halt      = 1'b1;
                        st_d.resume_pc = cur_pc + XLEN'(4);
                    end
                end
                default: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // read mux
    always_comb begin
        case (sel)
            SEL_VER:    spr_rdata = XLEN'(VERSION);
            SEL_EVB:    spr_rdata = st_q.evb;
            SEL_NPC:    spr_rdata = cur_pc;
            SEL_SR:     spr_rdata = st_q.sr;
            SEL_PPC:    spr_rdata = prev_pc;
            SEL_EPC:    spr_rdata = st_q.epc;
            SEL_EEA:    spr_rdata = st_q.eea;
            SEL_ESR:    spr_rdata = st_q.esr;
            SEL_SHADOW: spr_rdata = sh_rdata;
            SEL_MACLO:  spr_rdata = st_q.mac[XLEN-1:0];
            SEL_MACHI:  spr_rdata = st_q.mac[2*XLEN-1:XLEN];
            SEL_PWR:    spr_rdata = st_q.pwr;
            SEL_IMASK:  spr_rdata = st_q.imask;
            SEL_ISTAT:  spr_rdata = st_q.istat;
            default:    spr_rdata = spr_rd_prev;
        endcase
    end

    assign hit           = (sel != SEL_NONE);
    assign istat_q       = st_q.istat;
    assign mac_q         = st_q.mac;
    assign redirect_o    = st_q.redirect;
    assign dslot_clr_o   = st_q.redirect;
    assign redirect_pc_o = st_q.redirect_pc;
    assign halt_o        = st_q.halt;
    assign resume_pc_o   = st_q.resume_pc;
endmodule

// File: rtl/spr_unit_chk.sv
module spr_unit_chk
    import spr_pkg::*;
#(
    parameter int          XLEN    = 32,
    parameter logic [31:0] VERSION = 32'h1200_0301
) (
    input logic              clk,
    input logic              rst,
    input logic [15:0]       spr_addr,
    input logic              spr_we,
    input logic [XLEN-1:0]   spr_wdata,
    input logic [XLEN-1:0]   spr_rd_prev,
    input logic [XLEN-1:0]   spr_rdata,
    input logic [XLEN-1:0]   cur_pc,
    input logic [XLEN-1:0]   irq_set,
    input logic              redirect_o,
    input logic [XLEN-1:0]   redirect_pc_o,
    input logic              halt_o,
    input logic [XLEN-1:0]   resume_pc_o,
    input logic [XLEN-1:0]   istat_q,
    input logic [2*XLEN-1:0] mac_q,
    input logic              hit
);
    a_r3_clear_ones: assert property (@(posedge clk) disable iff (rst)
        (spr_we && spr_addr == A_ISTAT && irq_set == '0)
        |=> istat_q == ($past(istat_q) & ~$past(spr_wdata)));

    a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
        (irq_set != '0) |=> ((istat_q & $past(irq_set)) == $past(irq_set)));

    a_r6_hi_kept: assert property (@(posedge clk) disable iff (rst)
        (spr_we && spr_addr == A_MACLO)
        |=> mac_q[2*XLEN-1:XLEN] == $past(mac_q[2*XLEN-1:XLEN]));

    a_r6_lo_kept: assert property (@(posedge clk) disable iff (rst)
        (spr_we && spr_addr == A_MACHI)
        |=> mac_q[XLEN-1:0] == $past(mac_q[XLEN-1:0]));

    a_r8_prev_returned: assert property (@(posedge clk) disable iff (rst)
        !hit |-> spr_rdata == spr_rd_prev);

    a_r2_version: assert property (@(posedge clk) disable iff (rst)
        (spr_addr == A_VER) |-> spr_rdata == XLEN'(VERSION));

    a_r10_redirect_cause: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> ($past(spr_we) && $past(spr_addr) == A_NPC
                        && $past(spr_wdata) != $past(cur_pc)
                        && redirect_pc_o == $past(spr_wdata)));

    a_r11_resume_pc: assert property (@(posedge clk) disable iff (rst)
        halt_o |-> ($past(spr_addr) == A_PWR && resume_pc_o == $past(cur_pc) + XLEN'(4)));
endmodule

bind spr_unit spr_unit_chk #(.XLEN(XLEN), .VERSION(VERSION)) i_spr_unit_chk (.*);

// File: tb/test_spr_unit.sv
module test_spr_unit;
    localparam int          CLK_PERIOD = 10;
    localparam int          XLEN       = 32;
    localparam int          BANKS      = 2;
    localparam int          NSH        = BANKS * 32;
    localparam logic [31:0] VER        = 32'hC0DE_0007;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [15:0]     spr_addr = '0;
    logic            spr_we = 1'b0;
    logic [XLEN-1:0] spr_wdata = '0;
    logic [XLEN-1:0] spr_rd_prev = '0;
    logic [XLEN-1:0] spr_rdata;
    logic [XLEN-1:0] cur_pc = 32'h0000_1000;
    logic [XLEN-1:0] prev_pc = 32'h0000_0FFC;
    logic [XLEN-1:0] irq_set = '0;
    logic            redirect_o;
    logic [XLEN-1:0] redirect_pc_o;
    logic            dslot_clr_o;
    logic            halt_o;
    logic [XLEN-1:0] resume_pc_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model of the register contents
    logic [31:0] m_evb, m_sr, m_epc, m_eea, m_esr, m_mask, m_istat, m_pwr;
    logic [63:0] m_mac;
    logic [31:0] m_sh [NSH];

    always #(CLK_PERIOD/2) clk = ~clk;

    spr_unit #(.XLEN(XLEN), .BANKS(BANKS), .VERSION(VER)) i_spr_unit (
        .clk(clk), .rst(rst), .spr_addr(spr_addr), .spr_we(spr_we),
        .spr_wdata(spr_wdata), .spr_rd_prev(spr_rd_prev), .spr_rdata(spr_rdata),
        .cur_pc(cur_pc), .prev_pc(prev_pc), .irq_set(irq_set),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
        .dslot_clr_o(dslot_clr_o), .halt_o(halt_o), .resume_pc_o(resume_pc_o)
    );

    function automatic logic [15:0] num(input int g, input int i);
        return 16'((g << 11) + i);
    endfunction

    function automatic bit is_shadow(input int a);
        return a >= 1024 && a < 1024 + NSH;
    endfunction

    function automatic bit is_impl(input int a);
        return a == 0 || a == 11 || a == 16 || a == 17 || a == 18 || a == 32 ||
               a == 48 || a == 64 || is_shadow(a) || a == int'(num(5, 1)) ||
               a == int'(num(5, 2)) || a == int'(num(8, 0)) ||
               a == int'(num(9, 0)) || a == int'(num(9, 2));
    endfunction

    function automatic logic [31:0] model_rd(input int a, input logic [31:0] prev);
        if (is_shadow(a)) return m_sh[a - 1024];
        case (a)
            0:  return VER;
            11: return m_evb;
            16: return cur_pc;
            17: return m_sr;
            18: return prev_pc;
            32: return m_epc;
            48: return m_eea;
            64: return m_esr;
            default: ;
        endcase
        if (a == int'(num(5, 1))) return m_mac[31:0];
        if (a == int'(num(5, 2))) return m_mac[63:32];
        if (a == int'(num(8, 0))) return m_pwr;
        if (a == int'(num(9, 0))) return m_mask;
        if (a == int'(num(9, 2))) return m_istat;
        return prev;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        spr_addr  = a;
        spr_wdata = d;
        spr_we    = 1'b1;
        @(posedge clk);
        #1;
        spr_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] a, input logic [31:0] prev,
                          input logic [31:0] exp);
        spr_addr    = a;
        spr_rd_prev = prev;
        #1;
        chk(tag, spr_rdata, exp);
    endtask

    task automatic sweep_all(input string tag);
        for (int a = 0; a < 65536; a++) begin
            logic [31:0] pv;
            pv = ~{16'(a), 16'(a)} ^ 32'h5A5A_0000;
            rd_chk(tag, 16'(a), pv, model_rd(a, pv));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        m_evb = '0; m_sr = '0; m_epc = '0; m_eea = '0; m_esr = '0;
        m_mask = '0; m_istat = '0; m_pwr = '0; m_mac = '0;
        for (int i = 0; i < NSH; i++) m_sh[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R2: reset state across the whole space
        sweep_all("R2 reset");
        chk("R2 strobes idle", {redirect_o, halt_o, dslot_clr_o}, 3'b000);

        // R1 and R12: group 0 registers, readback right after the edge
        begin
            logic [15:0] ad [5];
            ad[0] = num(0, 11); ad[1] = num(0, 17); ad[2] = num(0, 32);
            ad[3] = num(0, 48); ad[4] = num(0, 64);
            for (int k = 0; k < 5; k++) begin
                logic [31:0] v;
                v = 32'h1111_1111 * (k + 3) ^ 32'h8000_0F0F;
                wr(ad[k], v);
                rd_chk("R12 readback next cycle", ad[k], 32'h0, v);
                case (k)
                    0: m_evb = v; 1: m_sr = v; 2: m_epc = v; 3: m_eea = v;
                    default: m_esr = v;
                endcase
            end
            for (int k = 0; k < 5; k++)
                rd_chk("R1 group0 register", ad[k], 32'h0, model_rd(int'(ad[k]), 32'h0));
        end

        // R5: mask replaced, not merged
        wr(num(9, 0), 32'hFFFF_0000); m_mask = 32'hFFFF_0000;
        wr(num(9, 0), 32'h0000_00F3); m_mask = 32'h0000_00F3;
        rd_chk("R5 mask replace", num(9, 0), 32'h0, 32'h0000_00F3);

        // R3: pending bits arrive, then write-one clears
        @(negedge clk); irq_set = 32'hA5A5_00FF;
        @(negedge clk); irq_set = '0;
        m_istat = 32'hA5A5_00FF;
        rd_chk("R4 set bits pend", num(9, 2), 32'h0, 32'hA5A5_00FF);
        wr(num(9, 2), 32'h0505_000F); m_istat = 32'hA0A0_00F0;
        rd_chk("R3 clear ones", num(9, 2), 32'h0, 32'hA0A0_00F0);
        wr(num(9, 2), 32'h0); 
        rd_chk("R3 zero write keeps", num(9, 2), 32'h0, 32'hA0A0_00F0);

        // R4: set and clear of the same bit in the same cycle
        @(negedge clk);
        spr_addr = num(9, 2); spr_wdata = 32'hA0A0_0030; spr_we = 1'b1;
        irq_set = 32'h0000_0010;
        @(posedge clk); #1;
        spr_we = 1'b0; irq_set = '0;
        m_istat = 32'h0000_00D0;
        rd_chk("R4 set beats clear", num(9, 2), 32'h0, 32'h0000_00D0);

        // R6: accumulator halves
        wr(num(5, 1), 32'hDEAD_BEEF); m_mac[31:0] = 32'hDEAD_BEEF;
        wr(num(5, 2), 32'h0123_4567); m_mac[63:32] = 32'h0123_4567;
        wr(num(5, 1), 32'h7777_8888); m_mac[31:0] = 32'h7777_8888;
        rd_chk("R6 high half kept", num(5, 2), 32'h0, 32'h0123_4567);
        rd_chk("R6 low half", num(5, 1), 32'h0, 32'h7777_8888);

        // R7: every shadow entry, distinct values
        for (int i = 0; i < NSH; i++) begin
            m_sh[i] = 32'h3C00_0000 + (i * 32'h0001_0203) ^ (32'(i / 32) << 20);
            wr(16'(1024 + i), m_sh[i]);
        end
        for (int i = 0; i < NSH; i++)
            rd_chk("R7 shadow entry", 16'(1024 + i), 32'h0, m_sh[i]);
        rd_chk("R7 above last bank", 16'(1024 + NSH), 32'h600D_F00D, 32'h600D_F00D);

        // R9: PC views
        cur_pc = 32'h0000_2468; prev_pc = 32'h0000_2464;
        rd_chk("R9 next pc view", num(0, 16), 32'h0, 32'h0000_2468);
        wr(num(0, 18), 32'hFFFF_FFFF);
        rd_chk("R9 prev pc write ignored", num(0, 18), 32'h0, 32'h0000_2464);

        // R10: redirect strobe
        wr(num(0, 16), 32'h0000_4000);
        chk("R10 redirect raised", {redirect_o, dslot_clr_o}, 2'b11);
        chk("R10 redirect target", redirect_pc_o, 32'h0000_4000);
        @(posedge clk); #1;
        chk("R10 redirect one cycle", {redirect_o, dslot_clr_o}, 2'b00);
        wr(num(0, 16), 32'h0000_2468);
        chk("R10 same pc no redirect", {redirect_o, dslot_clr_o}, 2'b00);

        // R11: power word and halt
        wr(num(8, 0), 32'h0000_0010); m_pwr = 32'h0000_0010;
        chk("R11 doze halts", halt_o, 1'b1);
        chk("R11 resume pc", resume_pc_o, 32'h0000_246C);
        @(posedge clk); #1;
        chk("R11 halt one cycle", halt_o, 1'b0);
        cur_pc = 32'h0000_8000;
        wr(num(8, 0), 32'h0000_0020); m_pwr = 32'h0000_0020;
        chk("R11 sleep halts", halt_o, 1'b1);
        chk("R11 resume pc sleep", resume_pc_o, 32'h0000_8004);
        wr(num(8, 0), 32'hFFFF_FFCF); m_pwr = 32'hFFFF_FFCF;
        chk("R11 other bits no halt", halt_o, 1'b0);
        rd_chk("R11 power readback", num(8, 0), 32'h0, 32'hFFFF_FFCF);

        // R8: writes to undecoded numbers change nothing
        for (int a = 5; a < 65536; a += 13)
            if (!is_impl(a)) wr(16'(a), 32'hBAD0_0000 | 32'(a));
        sweep_all("R8 full space after stray writes");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule